// File: doc/BRIEF.md
# Multi-Way Sequential Prefetch Stream Buffer

This block sits next to a first-level cache and answers its miss lookups from a set of small prefetch queues. Each queue follows one sequential stream of line addresses. When the cache controller presents a missing line address, only the oldest entry of each queue is compared with it. If an oldest entry matches, the line is returned from that queue, leaving the cache untouched. The entry is then retired and refilled with the next line of that stream. If no oldest entry matches, the least recently used queue is discarded. It is restarted on the lines that follow the missing one, and the cache fetches the missing line itself.

Fills come from a pipelined next-level memory that may have many requests in flight. Each request carries a tag equal to `queue * DEPTH + slot`, so fills can return in any order. A fill that belongs to a slot that has since been reassigned is dropped. A lookup that matches an oldest entry whose data has not yet arrived stalls the lookup port until the fill lands, then answers.

Top module: `strmbuf_top`

## Requirements
- R1: A lookup of line L that matches no queue's oldest entry is answered one cycle after acceptance with `rsp_hit`=0, and the replaced queue then requests lines L+1 up to L+DEPTH, lowest slot first.
- R2: A lookup that matches an oldest entry whose data is present is answered one cycle after acceptance with `rsp_hit`=1 and that line's data.
- R3: After such a hit on line X, the queue requests line X+DEPTH into the freed slot.
- R4: Only the oldest entry of each queue is compared; a lookup that equals a later entry counts as a miss.
- R5: Several queues track interleaved streams independently; alternating lookups of two streams all hit.
- R6: A lookup that matches an oldest entry whose data is still outstanding holds `lk_ready` low until the fill arrives, then answers with `rsp_hit`=1 and the correct data.
- R7: On a miss the least recently used queue is replaced, where both hits and allocations count as use; after reset queue 0 is replaced first, then 1, 2, 3.
- R8: A fill returning for a slot that was reassigned while its request was outstanding is discarded, and the slot is requested again for its new line.
- R9: The request tag is queue*DEPTH+slot; no tag is reissued while a request with that tag is outstanding, and fills are accepted in any order.
- R10: While `mreq_valid` is high and `mreq_ready` low, the request line and tag hold steady.
- R11: After reset, `lk_ready` is 1 and `rsp_valid` and `mreq_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Miss lookup presented |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_line | input | AW | Missing line address |
| rsp_valid | output | 1 | Lookup answer valid |
| rsp_hit | output | 1 | Line supplied by a queue |
| rsp_data | output | DW | Line data on a hit |
| mreq_valid | output | 1 | Fill request valid |
| mreq_ready | input | 1 | Memory accepts the request |
| mreq_line | output | AW | Line address to fetch |
| mreq_tag | output | TW | Request tag (queue*DEPTH+slot) |
| mrsp_valid | input | 1 | Fill returning |
| mrsp_tag | input | TW | Tag of the returning fill |
| mrsp_data | input | DW | Fill data |

## Verification
The main function is driven with a single fresh stream, two alternating streams, and lookups of non-oldest entries. These separate per-queue matching from a global compare and show whether only the oldest entry takes part. A run of allocations with one intervening hit pins down the replacement order as distinct from round-robin. A long memory latency is used both for an early lookup on a still-pending oldest entry and for replacing a queue whose fills are in flight. That setting tells stalling apart from answering early and exposes stale fills leaking into new lines. Fill latencies vary by tag so that responses return out of order, and a stretch of memory backpressure checks that a request stays steady while it waits.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_WAIT = 1'b1} sb_state_e;
endpackage

// File: rtl/sb_lru.sv
module sb_lru #(
  parameter int NB = 4,
  localparam int BW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          touch,
  input  logic [BW-1:0] touch_idx,
  output logic [BW-1:0] victim
);
  logic [NB-1:0][BW-1:0] age;

  always_comb begin
    victim = '0;
    for (int i = 0; i < NB; i++)
      if (age[i] == BW'(NB-1)) victim = BW'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NB; i++) age[i] <= BW'(NB-1-i);
    end else if (touch) begin
      for (int i = 0; i < NB; i++) begin
        if (BW'(i) == touch_idx) age[i] <= '0;
        else if (age[i] < age[touch_idx]) age[i] <= age[i] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sb_issue.sv
module sb_issue #(
  parameter int NS = 16,
  parameter int AW = 32,
  localparam int TW = $clog2(NS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NS-1:0]        want,
  input  logic [NS-1:0][AW-1:0] line_vec,
  input  logic                 mreq_ready,
  output logic                 mreq_valid,
  output logic [AW-1:0]        mreq_line,
  output logic [TW-1:0]        mreq_tag,
  output logic                 grant,
  output logic [TW-1:0]        grant_idx
);
  logic load;

  always_comb begin
    grant_idx = '0;
    for (int i = NS-1; i >= 0; i--)
      if (want[i]) grant_idx = TW'(i);
  end

  assign load  = !mreq_valid || mreq_ready;
  assign grant = load && (|want);

  always_ff @(posedge clk) begin
    if (rst) begin
      mreq_valid <= 1'b0;
      mreq_line  <= '0;
      mreq_tag   <= '0;
    end else if (load) begin
      mreq_valid <= |want;
      if (|want) begin
        mreq_line <= line_vec[grant_idx];
        mreq_tag  <= grant_idx;
      end
    end
  end
endmodule

// File: rtl/sb_store.sv
module sb_store #(
  parameter int NS = 16,
  parameter int DW = 64,
  localparam int TW = $clog2(NS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [TW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [TW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [NS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/strmbuf_top.sv
module strmbuf_top #(
  parameter int NB    = 4,
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 64,
  localparam int NS = NB * DEPTH,
  localparam int TW = $clog2(NS),
  localparam int PW = $clog2(DEPTH),
  localparam int BW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lk_valid,
  output logic          lk_ready,
  input  logic [AW-1:0] lk_line,
  output logic          rsp_valid,
  output logic          rsp_hit,
  output logic [DW-1:0] rsp_data,
  output logic          mreq_valid,
  input  logic          mreq_ready,
  output logic [AW-1:0] mreq_line,
  output logic [TW-1:0] mreq_tag,
  input  logic          mrsp_valid,
  input  logic [TW-1:0] mrsp_tag,
  input  logic [DW-1:0] mrsp_data
);
  import sb_pkg::*;

  sb_state_e             state;
  logic [BW-1:0]         wbuf;
  logic [NB-1:0]         buf_on;
  logic [NB-1:0][PW-1:0] hptr;
  logic [NS-1:0][AW-1:0] sline, sline_n;
  logic [NS-1:0]         need, infl, stale;
  logic [NS-1:0]         need_n, infl_n, stale_n;
  logic [NS-1:0]         have;
  logic [NB-1:0][TW-1:0] hidx;
  logic [NB-1:0]         hmatch;
  logic                  hit_any;
  logic [BW-1:0]         hit_buf, victim, pop_buf;
  logic [TW-1:0]         pop_idx, gidx;
  logic                  accept, hit_have, w_have, pop_go, alloc_go, grant;

  assign have     = ~need & ~infl;
  assign lk_ready = (state == ST_IDLE);
  assign accept   = lk_valid && lk_ready;

  for (genvar b = 0; b < NB; b++) begin : g_head
    assign hidx[b]   = TW'(b * DEPTH) + TW'(hptr[b]);
    assign hmatch[b] = buf_on[b] && (sline[hidx[b]] == lk_line);
  end

  always_comb begin
    hit_any = 1'b0;
    hit_buf = '0;
    for (int b = NB-1; b >= 0; b--)
      if (hmatch[b]) begin
        hit_any = 1'b1;
        hit_buf = BW'(b);
      end
  end

  assign hit_have = have[hidx[hit_buf]];
  assign w_have   = have[hidx[wbuf]];
  assign pop_go   = (accept && hit_any && hit_have) || (state == ST_WAIT && w_have);
  assign pop_buf  = (state == ST_WAIT) ? wbuf : hit_buf;
  assign pop_idx  = hidx[pop_buf];
  assign alloc_go = accept && !hit_any;

  sb_lru #(.NB(NB)) u_lru (
    .clk       (clk),
    .rst       (rst),
    .touch     (accept),
    .touch_idx (hit_any ? hit_buf : victim),
    .victim    (victim)
  );

  sb_issue #(.NS(NS), .AW(AW)) u_issue (
    .clk        (clk),
    .rst        (rst),
    .want       (need & ~infl),
    .line_vec   (sline),
    .mreq_ready (mreq_ready),
    .mreq_valid (mreq_valid),
    .mreq_line  (mreq_line),
    .mreq_tag   (mreq_tag),
    .grant      (grant),
    .grant_idx  (gidx)
  );

  sb_store #(.NS(NS), .DW(DW)) u_store (
    .clk   (clk),
    .we    (mrsp_valid && !stale[mrsp_tag]),
    .waddr (mrsp_tag),
    .wdata (mrsp_data),
    .raddr (pop_idx),
    .rdata (rsp_data)
  );

  // Slot bookkeeping: fill return, then issue, then reassignment (last wins).
  always_comb begin
    need_n  = need;
    infl_n  = infl;
    stale_n = stale;
    sline_n = sline;
    if (mrsp_valid) begin
      infl_n[mrsp_tag]  = 1'b0;
      stale_n[mrsp_tag] = 1'b0;
    end
    if (grant) begin
      need_n[gidx] = 1'b0;
      infl_n[gidx] = 1'b1;
    end
    if (pop_go) begin
      need_n[pop_idx]  = 1'b1;
      stale_n[pop_idx] = infl_n[pop_idx];
      sline_n[pop_idx] = sline[pop_idx] + AW'(DEPTH);
    end
    if (alloc_go) begin
      for (int s = 0; s < DEPTH; s++) begin
        need_n[int'(victim) * DEPTH + s]  = 1'b1;
        stale_n[int'(victim) * DEPTH + s] = infl_n[int'(victim) * DEPTH + s];
        sline_n[int'(victim) * DEPTH + s] = lk_line + AW'(s + 1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      wbuf      <= '0;
      buf_on    <= '0;
      hptr      <= '0;
      need      <= '0;
      infl      <= '0;
      stale     <= '0;
      sline     <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
    end else begin
      need  <= need_n;
      infl  <= infl_n;
      stale <= stale_n;
      sline <= sline_n;
      if (pop_go) hptr[pop_buf] <= hptr[pop_buf] + 1'b1;
      if (alloc_go) begin
        buf_on[victim] <= 1'b1;
        hptr[victim]   <= '0;
      end
      case (state)
        ST_IDLE: if (accept && hit_any && !hit_have) begin
          state <= ST_WAIT;
          wbuf  <= hit_buf;
        end
        ST_WAIT: if (w_have) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
      rsp_valid <= (accept && (!hit_any || hit_have)) || (state == ST_WAIT && w_have);
      rsp_hit   <= accept ? hit_any : 1'b1;
    end
  end
endmodule

// File: rtl/strmbuf_chk.sv
module strmbuf_chk #(
  parameter int NB    = 4,
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 64,
  localparam int NS = NB * DEPTH,
  localparam int TW = $clog2(NS)
) (
  input logic          clk,
  input logic          rst,
  input logic          lk_valid,
  input logic          lk_ready,
  input logic          rsp_valid,
  input logic          rsp_hit,
  input logic          mreq_valid,
  input logic          mreq_ready,
  input logic [AW-1:0] mreq_line,
  input logic [TW-1:0] mreq_tag,
  input logic          mrsp_valid,
  input logic [TW-1:0] mrsp_tag
);
  logic [NS-1:0] outst;

  always_ff @(posedge clk) begin
    if (rst) outst <= '0;
    else begin
      if (mrsp_valid) outst[mrsp_tag] <= 1'b0;
      if (mreq_valid && mreq_ready) outst[mreq_tag] <= 1'b1;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) $past(rst) |-> (lk_ready && !rsp_valid && !mreq_valid)); // R11
  AST_MISS_NEXT: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> $past(lk_valid && lk_ready)); // R1
  AST_RSP_SOURCE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($past(lk_valid && lk_ready) || $past(!lk_ready))); // R6
  AST_WAIT_ENDS_HIT: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(!lk_ready)) |-> (rsp_hit && lk_ready)); // R6
  AST_TAG_FREE: assert property (@(posedge clk) disable iff (rst)
    (mreq_valid && mreq_ready) |-> !outst[mreq_tag]); // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_line) && $stable(mreq_tag))); // R10
endmodule

bind strmbuf_top strmbuf_chk #(.NB(NB), .DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .lk_valid   (lk_valid),
  .lk_ready   (lk_ready),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .mreq_valid (mreq_valid),
  .mreq_ready (mreq_ready),
  .mreq_line  (mreq_line),
  .mreq_tag   (mreq_tag),
  .mrsp_valid (mrsp_valid),
  .mrsp_tag   (mrsp_tag)
);

// File: tb/sim_strmbuf_top.sv
module sim_strmbuf_top;
  localparam int NB = 4, DEPTH = 4, AW = 32, DW = 64;
  localparam int NS = NB * DEPTH, TW = $clog2(NS);

  logic clk = 1'b0, rst = 1'b1;
  logic lk_valid = 1'b0, lk_ready;
  logic [AW-1:0] lk_line = '0;
  logic rsp_valid, rsp_hit;
  logic [DW-1:0] rsp_data;
  logic mreq_valid, mreq_ready = 1'b1;
  logic [AW-1:0] mreq_line;
  logic [TW-1:0] mreq_tag;
  logic mrsp_valid = 1'b0;
  logic [TW-1:0] mrsp_tag = '0;
  logic [DW-1:0] mrsp_data = '0;

  int n_chk = 0, n_bad = 0;
  int slow = 0, stall = 0, dup_seen = 0, ooo_seen = 0, seq = 0;
  bit busy [NS];
  int cnt [NS], aseq [NS];
  logic [AW-1:0] bline [NS];
  logic [AW-1:0] log_line [1024];
  logic [TW-1:0] log_tag [1024];
  int log_n = 0;

  always #10 clk = ~clk;

  strmbuf_top #(.NB(NB), .DEPTH(DEPTH), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_line(lk_line),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_line(mreq_line), .mreq_tag(mreq_tag),
    .mrsp_valid(mrsp_valid), .mrsp_tag(mrsp_tag), .mrsp_data(mrsp_data));

  function automatic logic [DW-1:0] fdat(input logic [AW-1:0] l);
    return {~l, l};
  endfunction

  // Next-level memory model: variable latency per tag, so fills come back out of order.
  initial begin
    forever begin
      @(negedge clk);
      mrsp_valid = 1'b0;
      if (rst) begin
        for (int t = 0; t < NS; t++) busy[t] = 1'b0;
      end else begin
        for (int t = 0; t < NS; t++) begin
          if (busy[t] && cnt[t] == 0 && !mrsp_valid) begin
            mrsp_valid = 1'b1;
            mrsp_tag   = TW'(t);
            mrsp_data  = fdat(bline[t]);
            busy[t]    = 1'b0;
            for (int u = 0; u < NS; u++)
              if (busy[u] && aseq[u] < aseq[t]) ooo_seen++;
          end else if (busy[t] && cnt[t] > 0) cnt[t]--;
        end
        mreq_ready = (stall == 0);
        if (mreq_valid && mreq_ready) begin
          if (busy[mreq_tag]) dup_seen++;
          busy[mreq_tag]  = 1'b1;
          cnt[mreq_tag]   = slow + 1 + (int'(mreq_tag) * 3) % 5;
          bline[mreq_tag] = mreq_line;
          aseq[mreq_tag]  = seq++;
          if (log_n < 1024) begin
            log_line[log_n] = mreq_line;
            log_tag[log_n]  = mreq_tag;
            log_n++;
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; slow = 0; stall = 0; lk_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic look(input logic [AW-1:0] l, output logic h, output logic [DW-1:0] d, output int n);
    while (!lk_ready) @(negedge clk);
    lk_valid = 1'b1;
    lk_line  = l;
    @(negedge clk);
    lk_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 500) begin
      @(negedge clk);
      n++;
    end
    h = rsp_hit;
    d = rsp_data;
  endtask

  task automatic want_hit(input logic [AW-1:0] l, input string rq);
    logic h; logic [DW-1:0] d; int n;
    look(l, h, d, n);
    check(h == 1'b1, rq, DW'(h), 1);
    check(d == fdat(l), rq, d, fdat(l));
  endtask

  task automatic want_miss(input logic [AW-1:0] l, input string rq);
    logic h; logic [DW-1:0] d; int n;
    look(l, h, d, n);
    check(h == 1'b0 && n == 0, rq, {DW'(n), 1'b0} | DW'(h), 0);
  endtask

  task automatic t_reset();
    do_reset();
    check(lk_ready && !rsp_valid && !mreq_valid, "R11", {lk_ready, rsp_valid, mreq_valid}, 3'b100);
  endtask

  task automatic t_alloc_and_hit();
    int st;
    logic h; logic [DW-1:0] d; int n;
    do_reset();
    st = log_n;
    want_miss(32'h100, "R1");
    repeat (20) @(negedge clk);
    check(log_n - st == DEPTH, "R1", DW'(log_n - st), DEPTH);
    for (int s = 0; s < DEPTH; s++)
      check(log_line[st+s] == 32'h101 + s && log_tag[st+s] == TW'(s), "R1",
            DW'(log_line[st+s]), DW'(32'h101 + s));
    st = log_n;
    look(32'h101, h, d, n);
    check(h && n == 0, "R2", {DW'(n), h}, 1);
    check(d == fdat(32'h101), "R2", d, fdat(32'h101));
    repeat (12) @(negedge clk);
    check(log_n - st == 1 && log_line[st] == 32'h105 && log_tag[st] == 0, "R3",
          DW'(log_line[st]), 32'h105);
    for (int l = 32'h102; l <= 32'h108; l++) want_hit(AW'(l), "R3");
  endtask

  task automatic t_head_only();
    do_reset();
    want_miss(32'h300, "R4");
    repeat (20) @(negedge clk);
    want_miss(32'h302, "R4");
    want_hit(32'h301, "R4");
  endtask

  task automatic t_interleave();
    do_reset();
    want_miss(32'h1000, "R5");
    want_miss(32'h2000, "R5");
    repeat (30) @(negedge clk);
    for (int i = 1; i <= 7; i++) begin
      want_hit(32'h1000 + AW'(i), "R5");
      want_hit(32'h2000 + AW'(i), "R5");
    end
  endtask

  task automatic t_pending();
    logic h; logic [DW-1:0] d; int n;
    do_reset();
    slow = 20;
    want_miss(32'h800, "R6");
    look(32'h801, h, d, n);
    check(h && n >= 3, "R6", {DW'(n), h}, 1);
    check(d == fdat(32'h801), "R6", d, fdat(32'h801));
  endtask

  task automatic t_lru();
    do_reset();
    want_miss(32'h100, "R7");
    want_miss(32'h200, "R7");
    want_miss(32'h300, "R7");
    want_miss(32'h400, "R7");
    repeat (30) @(negedge clk);
    want_hit(32'h101, "R7");
    want_miss(32'h500, "R7");
    want_miss(32'h201, "R7");
    repeat (30) @(negedge clk);
    want_hit(32'h102, "R7");
    want_hit(32'h401, "R7");
    want_hit(32'h501, "R7");
    want_hit(32'h202, "R7");
    want_miss(32'h301, "R7");
  endtask

  task automatic t_stale();
    do_reset();
    slow = 40;
    want_miss(32'h900, "R8");
    want_miss(32'hA00, "R8");
    want_miss(32'hB00, "R8");
    want_miss(32'hC00, "R8");
    want_miss(32'hD00, "R8");
    repeat (150) @(negedge clk);
    for (int i = 1; i <= 4; i++) want_hit(32'hD00 + AW'(i), "R8");
    want_hit(32'hA01, "R8");
  endtask

  task automatic t_stall();
    logic [AW-1:0] l0; logic [TW-1:0] t0;
    do_reset();
    stall = 1;
    want_miss(32'hE00, "R10");
    repeat (5) @(negedge clk);
    l0 = mreq_line; t0 = mreq_tag;
    check(mreq_valid && l0 == 32'hE01 && t0 == 0, "R10", DW'(l0), 32'hE01);
    repeat (10) @(negedge clk);
    check(mreq_valid && mreq_line == l0 && mreq_tag == t0, "R10", DW'(mreq_line), DW'(l0));
    stall = 0;
    repeat (20) @(negedge clk);
    for (int i = 1; i <= 4; i++) want_hit(32'hE00 + AW'(i), "R10");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_alloc_and_hit();
    t_head_only();
    t_interleave();
    t_pending();
    t_lru();
    t_stale();
    t_stall();
    check(dup_seen == 0, "R9", DW'(dup_seen), 0);
    check(ooo_seen > 0, "R9", DW'(ooo_seen), 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule